// File: doc/BRIEF.md
# Mixed-Width Dual-Port Bit RAM

This block is a synchronous RAM of exactly 4096 bits with two ports, A and B. Each port has its own enable, write enable, synchronous output reset, address, write data and registered read data. A parameter sets the width of each port to 1, 2, 4, 8 or 16 bits, and the two widths may differ. Both ports look at the same bit array, so data written through a narrow port can be read back through a wide one, and the reverse. Width conversion therefore needs no extra logic.

A single clock drives both ports. The same-edge collision rule depends on that shared clock. Each port drives an output register through one of four named actions, chosen every cycle:
- OUT_HOLD keeps the value.
- OUT_INIT loads the reset value.
- OUT_ECHO shows the data just written.
- OUT_FETCH shows the addressed word.

Any action can follow any other. The choice depends only on that cycle's reset, enable and write enable.

Top module: `dual_width_ram`

## Requirements
- R1: Both ports address one shared 4096-bit array. The word at address k of a port of width W holds array bits W*k (the LSB of the data) up to W*k+W-1.
- R2: Each port width must be 1, 2, 4, 8 or 16 bits, giving depths of 4096, 2048, 1024, 512 or 256 and address widths of 12, 11, 10, 9 or 8. Any other width stops elaboration.
- R3: With reset low, enable high and write enable low at a rising edge, the port's output shows the addressed word after that edge.
- R4: With enable and write enable both high at a rising edge, the write data is stored at the addressed word.
- R5: A port that writes at an edge shows its own write data on its output after that edge.
- R6: With reset low and enable low, a port neither reads nor writes, and its output holds its value.
- R7: Reset high at an edge loads the port's output with its init parameter (INIT_A or INIT_B), whatever the enable. Reset does not alter the array.
- R8: When both ports write overlapping bits at the same edge, port A's data ends up in the overlapping bits. Port B's non-overlapping bits are still written.
- R9: A read at an edge where the other port writes the same bits returns the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_rst | input | 1 | Port A synchronous output reset |
| a_addr | input | 12 - log2(WIDTH_A) | Port A word address |
| a_wdata | input | WIDTH_A | Port A write data |
| a_rdata | output | WIDTH_A | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_rst | input | 1 | Port B synchronous output reset |
| b_addr | input | 12 - log2(WIDTH_B) | Port B word address |
| b_wdata | input | WIDTH_B | Port B write data |
| b_rdata | output | WIDTH_B | Port B registered read data |

## Verification
The assertions assume that every control input holds a known level at each rising edge from the first one onward. They also assume that the reset, enable and write-enable inputs of a port are the only things that decide the next value of its output register. The bench drives every input from time zero and changes inputs only just after a rising edge, so each edge sees settled, defined values. No part of the array is read through either port until the bench has written it. The bench therefore never compares against the array's undefined power-up contents.

// File: rtl/dwram_pkg.sv
package dwram_pkg;

    localparam int unsigned STORE_BITS = 4096;
    localparam int unsigned STORE_IDX  = $clog2(STORE_BITS);

    typedef enum logic [1:0] {
        OUT_HOLD,
        OUT_INIT,
        OUT_ECHO,
        OUT_FETCH
    } out_act_t;

    function automatic bit width_ok(input int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

    function automatic int unsigned addr_bits(input int unsigned w);
        return STORE_IDX - $clog2(w);
    endfunction

endpackage

// File: rtl/dwram_lane.sv
module dwram_lane #(
    parameter int unsigned W  = 4,
    parameter int unsigned AW = 10
) (
    input  logic [AW-1:0]                       addr,
    input  logic [W-1:0]                        wdata,
    input  logic                                wr,
    input  logic [dwram_pkg::STORE_BITS-1:0]    store,
    output logic [dwram_pkg::STORE_BITS-1:0]    mask,
    output logic [dwram_pkg::STORE_BITS-1:0]    place,
    output logic [W-1:0]                        rword
);
    import dwram_pkg::*;

    localparam int unsigned PAD = STORE_BITS - W;

    logic [STORE_IDX-1:0] base;

    always_comb begin
        base  = STORE_IDX'(addr) * STORE_IDX'(W);
        mask  = {{PAD{1'b0}}, {W{wr}}} << base;
        place = {{PAD{1'b0}}, wdata} << base;
        rword = store[base +: W];
    end

endmodule

// File: rtl/dwram_store.sv
module dwram_store (
    input  logic                                clk,
    input  logic [dwram_pkg::STORE_BITS-1:0]    a_mask,
    input  logic [dwram_pkg::STORE_BITS-1:0]    a_place,
    input  logic [dwram_pkg::STORE_BITS-1:0]    b_mask,
    input  logic [dwram_pkg::STORE_BITS-1:0]    b_place,
    output logic [dwram_pkg::STORE_BITS-1:0]    store
);
    import dwram_pkg::*;

    logic [STORE_BITS-1:0] after_b;
    logic [STORE_BITS-1:0] after_a;

    // Port B lands first, port A overrides it on any shared bit.
    always_comb begin
        after_b = (store & ~b_mask) | (b_place & b_mask);
        after_a = (after_b & ~a_mask) | (a_place & a_mask);
    end

    always_ff @(posedge clk) begin
        store <= after_a;
    end

endmodule

// File: rtl/dwram_outreg.sv
module dwram_outreg #(
    parameter int unsigned W         = 4,
    parameter logic [W-1:0] INIT_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rword,
    output logic [W-1:0] q
);
    import dwram_pkg::*;

    out_act_t act;

    always_comb begin
        if (rst)
            act = OUT_INIT;
        else if (!en)
            act = OUT_HOLD;
        else if (we)
            act = OUT_ECHO;
        else
            act = OUT_FETCH;
    end

    always_ff @(posedge clk) begin
        unique case (act)
            OUT_HOLD:  q <= q;
            OUT_INIT:  q <= INIT_VAL;
            OUT_ECHO:  q <= wdata;
            OUT_FETCH: q <= rword;
            default:   q <= q;
        endcase
    end

endmodule

// File: rtl/dual_width_ram.sv
module dual_width_ram #(
    parameter int unsigned WIDTH_A        = 4,
    parameter int unsigned WIDTH_B        = 16,
    parameter logic [WIDTH_A-1:0] INIT_A  = '0,
    parameter logic [WIDTH_B-1:0] INIT_B  = '0,
    localparam int unsigned AW_A          = dwram_pkg::addr_bits(WIDTH_A),
    localparam int unsigned AW_B          = dwram_pkg::addr_bits(WIDTH_B)
) (
    input  logic               clk,
    input  logic               a_en,
    input  logic               a_we,
    input  logic               a_rst,
    input  logic [AW_A-1:0]    a_addr,
    input  logic [WIDTH_A-1:0] a_wdata,
    output logic [WIDTH_A-1:0] a_rdata,
    input  logic               b_en,
    input  logic               b_we,
    input  logic               b_rst,
    input  logic [AW_B-1:0]    b_addr,
    input  logic [WIDTH_B-1:0] b_wdata,
    output logic [WIDTH_B-1:0] b_rdata
);
    import dwram_pkg::*;

    // R2: only power-of-two widths up to 16 are legal
    if (!width_ok(WIDTH_A) || !width_ok(WIDTH_B)) begin : g_bad_width
        $error("dual_width_ram: port widths must be 1, 2, 4, 8 or 16");
    end

    logic [STORE_BITS-1:0] store;
    logic [STORE_BITS-1:0] a_mask, a_place, b_mask, b_place;
    logic [WIDTH_A-1:0]    a_word;
    logic [WIDTH_B-1:0]    b_word;
    logic                  a_wr, b_wr;

    assign a_wr = a_en & a_we;
    assign b_wr = b_en & b_we;

    dwram_lane #(.W(WIDTH_A), .AW(AW_A)) u_lane_a (
        .addr  (a_addr),
        .wdata (a_wdata),
        .wr    (a_wr),
        .store (store),
        .mask  (a_mask),
        .place (a_place),
        .rword (a_word)
    );

    dwram_lane #(.W(WIDTH_B), .AW(AW_B)) u_lane_b (
        .addr  (b_addr),
        .wdata (b_wdata),
        .wr    (b_wr),
        .store (store),
        .mask  (b_mask),
        .place (b_place),
        .rword (b_word)
    );

    dwram_store u_store (
        .clk     (clk),
        .a_mask  (a_mask),
        .a_place (a_place),
        .b_mask  (b_mask),
        .b_place (b_place),
        .store   (store)
    );

    dwram_outreg #(.W(WIDTH_A), .INIT_VAL(INIT_A)) u_out_a (
        .clk   (clk),
        .rst   (a_rst),
        .en    (a_en),
        .we    (a_we),
        .wdata (a_wdata),
        .rword (a_word),
        .q     (a_rdata)
    );

    dwram_outreg #(.W(WIDTH_B), .INIT_VAL(INIT_B)) u_out_b (
        .clk   (clk),
        .rst   (b_rst),
        .en    (b_en),
        .we    (b_we),
        .wdata (b_wdata),
        .rword (b_word),
        .q     (b_rdata)
    );

endmodule

// File: rtl/dwram_checker.sv
module dwram_checker #(
    parameter int unsigned WA = 4,
    parameter int unsigned WB = 16,
    parameter logic [WA-1:0] IA = '0,
    parameter logic [WB-1:0] IB = '0
) (
    input logic          clk,
    input logic          a_en,
    input logic          a_we,
    input logic          a_rst,
    input logic [WA-1:0] a_wdata,
    input logic [WA-1:0] a_rdata,
    input logic          b_en,
    input logic          b_we,
    input logic          b_rst,
    input logic [WB-1:0] b_wdata,
    input logic [WB-1:0] b_rdata
);

    p_rst_init_a_r7: assert property (@(posedge clk) a_rst |=> (a_rdata == IA));
    p_rst_init_b_r7: assert property (@(posedge clk) b_rst |=> (b_rdata == IB));

    p_hold_a_r6: assert property (@(posedge clk) disable iff (a_rst)
        (!a_en) |=> $stable(a_rdata));
    p_hold_b_r6: assert property (@(posedge clk) disable iff (b_rst)
        (!b_en) |=> $stable(b_rdata));

    p_wfirst_a_r5: assert property (@(posedge clk) disable iff (a_rst)
        (a_en && a_we) |=> (a_rdata == $past(a_wdata)));
    p_wfirst_b_r5: assert property (@(posedge clk) disable iff (b_rst)
        (b_en && b_we) |=> (b_rdata == $past(b_wdata)));

endmodule

bind dual_width_ram dwram_checker #(
    .WA(WIDTH_A), .WB(WIDTH_B), .IA(INIT_A), .IB(INIT_B)
) u_dwram_chk (
    .clk     (clk),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_rst   (a_rst),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_rst   (b_rst),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
);

// File: tb/dual_width_ram_test.sv
module dual_width_ram_test;

    localparam int WA  = 4;
    localparam int WB  = 16;
    localparam int AWA = 10;
    localparam int AWB = 8;
    localparam logic [WA-1:0] IA = 4'hA;
    localparam logic [WB-1:0] IB = 16'h5A3C;

    logic           clk = 1'b0;
    logic           a_en, a_we, a_rst, b_en, b_we, b_rst;
    logic [AWA-1:0] a_addr;
    logic [AWB-1:0] b_addr;
    logic [WA-1:0]  a_wdata, a_rdata;
    logic [WB-1:0]  b_wdata, b_rdata;

    logic [4095:0]  model;
    int             checks = 0;
    int             errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    dual_width_ram #(.WIDTH_A(WA), .WIDTH_B(WB), .INIT_A(IA), .INIT_B(IB)) uut (
        .clk(clk),
        .a_en(a_en), .a_we(a_we), .a_rst(a_rst), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_rst(b_rst), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        a_en = 0; a_we = 0; a_rst = 0;
        b_en = 0; b_we = 0; b_rst = 0;
    endtask

    task automatic chk_a(input string req, input logic [WA-1:0] exp);
        checks++;
        if (a_rdata !== exp) begin
            errors++;
            $display("FAIL %s: a_rdata=%h expected %h", req, a_rdata, exp);
        end
    endtask

    task automatic chk_b(input string req, input logic [WB-1:0] exp);
        checks++;
        if (b_rdata !== exp) begin
            errors++;
            $display("FAIL %s: b_rdata=%h expected %h", req, b_rdata, exp);
        end
    endtask

    function automatic logic [WA-1:0] pat_a(input int k);
        return WA'((k * 5 + 3) ^ (k >> 4));
    endfunction

    function automatic logic [WB-1:0] pat_b(input int j);
        return WB'((j * 40503) ^ 4660);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [WA-1:0] held;
        idle();
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        model = '0;

        // R7: reset state of both outputs
        a_rst = 1; b_rst = 1;
        tick();
        chk_a("R7 reset A", IA);
        chk_b("R7 reset B", IB);
        idle();

        // R4/R5: fill the array through the 4-bit port
        for (int k = 0; k < 1024; k++) begin
            a_en = 1; a_we = 1; a_addr = AWA'(k); a_wdata = pat_a(k);
            tick();
            chk_a("R5 write-first A", pat_a(k));
            model[k*WA +: WA] = pat_a(k);
        end
        idle();

        // R1/R3: read every 16-bit word back through port B
        for (int j = 0; j < 256; j++) begin
            b_en = 1; b_addr = AWB'(j);
            tick();
            chk_b("R1 wide view of narrow writes", model[j*WB +: WB]);
        end
        idle();

        // R4/R5: overwrite everything through the 16-bit port
        for (int j = 0; j < 256; j++) begin
            b_en = 1; b_we = 1; b_addr = AWB'(j); b_wdata = pat_b(j);
            tick();
            chk_b("R5 write-first B", pat_b(j));
            model[j*WB +: WB] = pat_b(j);
        end
        idle();

        // R1/R3: read every nibble back through port A
        for (int k = 0; k < 1024; k++) begin
            a_en = 1; a_addr = AWA'(k);
            tick();
            chk_a("R3 narrow view of wide writes", model[k*WA +: WA]);
        end
        idle();

        // R6: enable low with write enable high changes nothing
        held = a_rdata;
        a_en = 0; a_we = 1; a_addr = 10'd5; a_wdata = ~model[5*WA +: WA];
        tick();
        chk_a("R6 output held", held);
        tick();
        chk_a("R6 output still held", held);
        idle();
        a_en = 1; a_addr = 10'd5;
        tick();
        chk_a("R6 memory untouched", model[5*WA +: WA]);
        idle();

        // R7: reset ignores enable and leaves memory intact
        a_rst = 1; a_en = 0;
        tick();
        chk_a("R7 reset with enable low", IA);
        a_rst = 0; a_en = 1; a_addr = 10'd7;
        tick();
        chk_a("R7 memory kept over reset", model[7*WA +: WA]);
        idle();

        // R8: both ports write overlapping bits, A wins the overlap
        a_en = 1; a_we = 1; a_addr = 10'd8; a_wdata = 4'h3;
        b_en = 1; b_we = 1; b_addr = 8'd2; b_wdata = 16'hBEEF;
        tick();
        chk_a("R8 A echo on collision", 4'h3);
        chk_b("R8 B echo on collision", 16'hBEEF);
        model[2*WB +: WB] = 16'hBEEF;
        model[8*WA +: WA] = 4'h3;
        idle();
        b_en = 1; b_addr = 8'd2;
        tick();
        chk_b("R8 merged word", 16'hBEE3);
        idle();

        // R9: B reads bits A writes on the same edge, gets old data
        a_en = 1; a_we = 1; a_addr = 10'd12; a_wdata = ~model[12*WA +: WA];
        b_en = 1; b_we = 0; b_addr = 8'd3;
        tick();
        chk_b("R9 read-before-write across ports", model[3*WB +: WB]);
        model[12*WA +: WA] = ~model[12*WA +: WA];
        idle();
        b_en = 1; b_addr = 8'd3;
        tick();
        chk_b("R9 new data next read", model[3*WB +: WB]);
        idle();

        // R2: port widths 4 and 16 imply address widths 10 and 8
        checks++;
        if ($bits(a_addr) != 10 || $bits(b_addr) != 8) begin
            errors++;
            $display("FAIL R2: addr widths %0d/%0d expected 10/8", $bits(a_addr), $bits(b_addr));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule